// File: doc/BRIEF.md
# Test Output Selector with Divider Bypass

This block decides what appears on a single test pin of a clock synthesizer. A 3-bit select code picks one of eight sources. Three are plain levels: a constant high, a constant low, and the bit leaving the serial configuration shift register. Two are passed through as they arrive: the reference clock and the synthesized output clock. Three are derived inside the block: the loop counter output halved by a toggle stage, the output clock divided by four, and a bypass view of the loop counter.

The loop counter divides its clock by a 9-bit modulus. Its raw output is a single-cycle pulse, so a toggle flip-flop turns it into a square wave at half the pulse rate.

In bypass mode the block raises a select line. An external clock multiplexer uses that line to feed the serial interface clock, instead of the oscillator-domain clock, into both the loop counter and the output divider. The counter and divider state in this block therefore run on whichever clock that multiplexer delivers on `clk`. While the parallel load strobe is low, the select code is treated as its all-zero value, which shows the shift-register bit and keeps the pin quiet for jitter.

Top module: `test_out_sel`

## Requirements
- R1: With effective code 000 the test pin equals `shift_bit`, with no clock delay.
- R2: Code 001 drives the test pin high and code 101 drives it low.
- R3: Code 010 places `ref_in` on the test pin, with no clock delay.
- R4: Code 100 places `fout_in` on the test pin, with no clock delay.
- R5: With code 011 the test pin is the loop counter output halved. It changes state once every M clock cycles, where M is `m_val` for M of 2 or more and 1 for M of 0 or 1.
- R6: Code 110 shows the same halved loop counter signal on the test pin. `bypass_sel` is 1 exactly when the effective code is 110, and 0 for every other code.
- R7: With code 111 the test pin is bit 1 of a count of `fout_in` rising edges, sampled on `clk`. After k rising edges since reset, the pin equals (k>>1)&1.
- R8: While `pload_n` is 0 the effective code is 000: the pin follows `shift_bit` and `bypass_sel` is 0, whatever `t_code` holds.
- R9: Synchronous active-low reset clears the loop counter, its toggle stage and the divide-by-four state. Right after reset, codes 011, 110 and 111 all show 0.
- R10: A new `m_val` takes effect at the next reload. The count already in progress completes with the old modulus, and the count after it uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider clock: oscillator-domain clock, or serial clock in bypass, chosen externally |
| rst_n | input | 1 | Synchronous active-low reset |
| pload_n | input | 1 | Parallel load strobe level; low forces code 000 |
| t_code | input | 3 | Test select code |
| m_val | input | 9 | Loop counter modulus |
| shift_bit | input | 1 | Serial shift register output bit |
| ref_in | input | 1 | Reference clock |
| fout_in | input | 1 | Synthesized output clock (output divider result) |
| test_pin | output | 1 | Selected test signal |
| bypass_sel | output | 1 | High when the serial clock must drive the dividers |

## Verification
The pass-through and constant selections and `bypass_sel` are combinational, so the bench checks them 1 ns after the inputs change at a falling edge, with no clock edge in between. The halved loop counter moves one clock after the counter's pulse register, so the first change comes two rising edges after reset. The bench therefore measures spacing between consecutive transitions, sampled at falling edges, rather than absolute times. The divide-by-four output updates on the first rising edge of `clk` that sees `fout_in` high, so the bench waits several cycles after each `fout_in` edge before sampling. A modulus change is checked by expecting one more interval at the old modulus before the new one applies.

// File: rtl/tos_pkg.sv
// Shared types for the test output selector.
// Assumes the select code is exactly three bits wide.
package tos_pkg;
    typedef enum logic [2:0] {
        TC_SHIFT   = 3'b000,
        TC_HIGH    = 3'b001,
        TC_REF     = 3'b010,
        TC_LOOPDV2 = 3'b011,
        TC_FOUT    = 3'b100,
        TC_LOW     = 3'b101,
        TC_BYPASS  = 3'b110,
        TC_FOUTQ   = 3'b111
    } test_code_e;
endpackage

// File: rtl/tos_loop_div.sv
// Programmable loop counter: emits a one-cycle tick every MODULUS cycles.
// Assumes modulus values of 0 and 1 both mean "tick every cycle".
// The modulus is sampled only at reload, so a change applies to the next count.
module tos_loop_div #(
    parameter int MW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] modulus,
    output logic          tick
);
    logic [MW-1:0] cnt;
    logic [MW-1:0] reload;

    // Reload value is modulus minus one, clamped at zero.
    always_comb begin
        reload = (modulus > MW'(1)) ? (modulus - MW'(1)) : '0;
    end

    // Down-counter with reload and a registered terminal-count tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= reload;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - MW'(1);
            tick <= 1'b0;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $stable(modulus) && modulus > MW'(1)) |=> !tick); // R5
endmodule

// File: rtl/tos_toggle.sv
// Toggle stage: flips its output on each input tick, halving the tick rate.
// Assumes the tick is one cycle wide and synchronous to clk.
module tos_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic q
);
    // Flip state on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else if (tick) q <= ~q;
    end

    AST_TOG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> $past(tick)); // R5
endmodule

// File: rtl/tos_quarter.sv
// Divides a level signal by 2**QW: counts its rising edges sampled on clk.
// Assumes the level is slower than clk/2 so that every edge is seen.
module tos_quarter #(
    parameter int QW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic q
);
    logic          prev;
    logic [QW-1:0] cnt;

    // Remember the last level and count detected rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            cnt  <= '0;
        end else begin
            prev <= lvl;
            if (lvl && !prev) cnt <= cnt + QW'(1);
        end
    end

    assign q = cnt[QW-1];

    AST_QCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> $past(lvl && !prev)); // R7
endmodule

// File: rtl/test_out_sel.sv
// Test output selector: picks one of eight sources for the test pin from a
// 3-bit code, forced to code 000 while the parallel load strobe is low.
// Assumes clk already comes from the external divider clock multiplexer,
// which follows bypass_sel. The selection is combinational.
module test_out_sel
    import tos_pkg::*;
#(
    parameter int MW = 9,
    parameter int QW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pload_n,
    input  logic [2:0]    t_code,
    input  logic [MW-1:0] m_val,
    input  logic          shift_bit,
    input  logic          ref_in,
    input  logic          fout_in,
    output logic          test_pin,
    output logic          bypass_sel
);
    test_code_e t_eff;
    logic       loop_tick;
    logic       loop_half;
    logic       fout_div;

    tos_loop_div #(.MW(MW)) u_loop (
        .clk(clk), .rst_n(rst_n), .modulus(m_val), .tick(loop_tick)
    );

    tos_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .tick(loop_tick), .q(loop_half)
    );

    tos_quarter #(.QW(QW)) u_quarter (
        .clk(clk), .rst_n(rst_n), .lvl(fout_in), .q(fout_div)
    );

    // Effective code: the strobe held low forces the quiet selection.
    always_comb begin
        t_eff = pload_n ? test_code_e'(t_code) : TC_SHIFT;
    end

    // Test pin source multiplexer and bypass indication.
    always_comb begin
        bypass_sel = 1'b0;
        unique case (t_eff)
            TC_SHIFT:   test_pin = shift_bit;
            TC_HIGH:    test_pin = 1'b1;
            TC_REF:     test_pin = ref_in;
            TC_LOOPDV2: test_pin = loop_half;
            TC_FOUT:    test_pin = fout_in;
            TC_LOW:     test_pin = 1'b0;
            TC_BYPASS: begin
                test_pin   = loop_half;
                bypass_sel = 1'b1;
            end
            default:    test_pin = fout_div;
        endcase
    end

    AST_FORCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pload_n |-> (test_pin == shift_bit && !bypass_sel)); // R8
    AST_BYPASS_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_sel |-> (test_pin == loop_half && pload_n)); // R6
    AST_CONST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pload_n && t_code == 3'b001) |-> test_pin); // R2
    AST_CONST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pload_n && t_code == 3'b101) |-> !test_pin); // R2
endmodule

// File: tb/sim_test_out_sel.sv
module sim_test_out_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pload_n = 1'b1;
    logic [2:0] t_code = 3'b000;
    logic [8:0] m_val = 9'd4;
    logic       shift_bit = 1'b0;
    logic       ref_in = 1'b0;
    logic       fout_in = 1'b0;
    logic       test_pin;
    logic       bypass_sel;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    test_out_sel u0 (
        .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .t_code(t_code),
        .m_val(m_val), .shift_bit(shift_bit), .ref_in(ref_in),
        .fout_in(fout_in), .test_pin(test_pin), .bypass_sel(bypass_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected pin for the combinational selections.
    function automatic logic exp_comb(input logic ld, input logic [2:0] c,
                                      input logic s, input logic r, input logic f);
        logic [2:0] e;
        e = ld ? c : 3'b000;
        case (e)
            3'b000:  return s;
            3'b001:  return 1'b1;
            3'b010:  return r;
            3'b100:  return f;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int exp_half(input int m);
        return (m <= 1) ? 1 : m;
    endfunction

    task automatic do_reset(input int m, input logic [2:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        m_val = 9'(m);
        t_code = c;
        pload_n = 1'b1;
        fout_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Measure three half-periods of the halved loop counter on the pin.
    task automatic run_div(input int m, input logic [2:0] c, input string req);
        int last;
        int seen;
        int cyc;
        int lim;
        logic prev;
        do_reset(m, c);
        last = -1; seen = 0; cyc = 0; prev = 1'b0;
        lim = 4 * exp_half(m) + 20;
        while (seen < 4 && cyc < lim) begin
            @(negedge clk);
            cyc++;
            if (test_pin !== prev) begin
                prev = test_pin;
                if (last >= 0) check(cyc - last == exp_half(m), req, cyc - last, exp_half(m));
                last = cyc;
                seen++;
            end
        end
        check(seen == 4, {req, " transitions"}, seen, 4);
    endtask

    initial begin
        logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101};
        void'($urandom(32'd4242));

        // R9: state after reset for the three derived selections.
        do_reset(5, 3'b011);
        #1 check(test_pin == 1'b0, "R9 loop half after reset", test_pin, 0);
        t_code = 3'b110;
        #1 check(test_pin == 1'b0, "R9 bypass view after reset", test_pin, 0);
        t_code = 3'b111;
        #1 check(test_pin == 1'b0, "R9 quarter after reset", test_pin, 0);

        // R1 R2 R3 R4 R8: random combinational selections.
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            pload_n   = ($urandom % 4) != 0;
            t_code    = codes[$urandom % 5];
            shift_bit = 1'($urandom);
            ref_in    = 1'($urandom);
            fout_in   = 1'($urandom);
            #1 check(test_pin == exp_comb(pload_n, t_code, shift_bit, ref_in, fout_in),
                     "R1/R2/R3/R4/R8 comb select", test_pin,
                     exp_comb(pload_n, t_code, shift_bit, ref_in, fout_in));
        end

        // R6 R8: bypass indication for all codes and strobe levels.
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            pload_n = 1'($urandom);
            t_code  = 3'($urandom);
            #1 check(bypass_sel == (pload_n && t_code == 3'b110), "R6 bypass_sel",
                     bypass_sel, int'(pload_n && t_code == 3'b110));
        end
        @(negedge clk);
        pload_n = 1'b0; t_code = 3'b110; shift_bit = 1'b1;
        #1 check(bypass_sel == 1'b0 && test_pin == 1'b1, "R8 strobe low forces 000",
                 {bypass_sel, test_pin}, 1);

        // R5: halved loop counter, directed and random moduli.
        run_div(2, 3'b011, "R5 m=2");
        run_div(0, 3'b011, "R5 m=0");
        run_div(1, 3'b011, "R5 m=1");
        run_div(511, 3'b011, "R5 m=511");
        for (int i = 0; i < 3; i++) run_div(2 + int'($urandom % 39), 3'b011, "R5 random m");

        // R6: bypass view with an odd modulus.
        run_div(7, 3'b110, "R6 bypass m=7");
        check(bypass_sel == 1'b1, "R6 bypass_sel in bypass", bypass_sel, 1);

        // R10: modulus change applies after the current count.
        begin
            int last;
            int ivl [3];
            int n;
            int cyc;
            logic prev;
            do_reset(4, 3'b011);
            last = -1; n = 0; cyc = 0; prev = 1'b0;
            while (n < 3 && cyc < 200) begin
                @(negedge clk);
                cyc++;
                if (test_pin !== prev) begin
                    prev = test_pin;
                    if (last >= 0) begin ivl[n] = cyc - last; n++; end
                    else m_val = 9'd7;
                    last = cyc;
                end
            end
            check(n == 3 && ivl[0] == 4, "R10 old modulus finishes", ivl[0], 4);
            check(n == 3 && ivl[1] == 7, "R10 new modulus applies", ivl[1], 7);
            check(n == 3 && ivl[2] == 7, "R10 new modulus holds", ivl[2], 7);
        end

        // R7: divide by four of the output clock.
        do_reset(4, 3'b111);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            fout_in = 1'b1;
            repeat (3) @(negedge clk);
            fout_in = 1'b0;
            repeat (3) @(negedge clk);
            check(test_pin == 1'((k >> 1) & 1), "R7 quarter", test_pin, (k >> 1) & 1);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule